// File: doc/BRIEF.md
# Banked Write-Back Data Cache with Associative Tag Search

This block is a write-back data cache whose tag store works as a content-addressable memory. Each request selects one bank from fixed address bits. The request tag is then compared against every way of that bank at the same time. Only the single data row whose tag matched is read or written, so the other ways of the set are never accessed. Loads and stores that hit are answered one cycle after the request. A store that hits changes only the enabled bytes and marks the line dirty; nothing goes to the next memory level.

A request that misses is answered with a miss pulse. The pulse comes with the line address and a report on the line chosen for eviction: its way, whether it was valid, whether it was dirty, and its tag. An external refill controller uses a second data port to write the new line word by word. Each fill write returns the word it overwrote, so a dirty victim is streamed out while the new line streams in. The controller then installs the new tag. A flush input, or the synchronous reset, empties the cache in one cycle.

With the default parameters there are 16 banks of 32 ways each, 32-byte lines and 32-bit words. That gives 512 lines and 16 KB of data in total.

Top module: `ccam_cache`

## Requirements
- R1: The request is a word address, equal to byte address bits 31:2. Byte address bits 4:2 select the word within the line, bits 8:5 select the bank, and bits 31:9 form the tag. The same tag held in two banks names two independent lines.
- R2: A load whose tag matches a valid way of its bank raises `cpu_hit` one cycle after the request, and `cpu_rdata` carries that way's word in the same cycle. At most one way of a bank ever matches.
- R3: A store hit writes only the bytes whose `cpu_be` bits are set (bit k covers data bits 8k+7:8k) and marks the line dirty. It does not raise `cpu_miss`.
- R4: A request that matches no valid way raises `cpu_miss` for one cycle, one cycle after the request, and presents the line address (byte address bits 31:5) on `miss_line`. A store miss changes no data and no dirty bit. `cpu_hit` and `cpu_miss` are never high together, and both are low in any cycle that follows a cycle without a request.
- R5: On a miss, the victim is the lowest-numbered invalid way of the bank, if one exists. The bank's replacement pointer then does not move.
- R6: On a miss in a bank whose ways are all valid, the victim is the way named by that bank's own pointer. The pointer then advances by one and wraps from the last way to way 0. Other banks' pointers are not affected.
- R7: With a miss, `vic_valid`, `vic_dirty` and `vic_tag` report the victim's state before the miss. The line is dirty only if a store has hit it since it was installed.
- R8: A fill write stores `fill_wdata` at the word selected by bank, way and word index. One cycle later, `fill_rdata` returns the word that was there before the write.
- R9: An install makes the given way valid and clean, with the tag from `inst_line`. A lookup in the same cycle as the install is judged against the contents before the install. Lookups from the next cycle on see the new line.
- R10: Reset or `flush` clears every valid bit, every dirty bit and every replacement pointer at the next clock edge, and overrides any install or dirty update in the same cycle. A lookup in the flush cycle is still judged against the contents before the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate every line in one cycle |
| cpu_req | input | 1 | Load or store request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_be | input | 4 | Store byte enables |
| cpu_waddr | input | 30 | Word address (byte address bits 31:2) |
| cpu_wdata | input | 32 | Store data |
| cpu_hit | output | 1 | Request of the previous cycle hit |
| cpu_miss | output | 1 | Request of the previous cycle missed |
| cpu_rdata | output | 32 | Load data of a hit |
| miss_line | output | 27 | Line address of the missed request |
| vic_way | output | 5 | Way chosen for replacement |
| vic_valid | output | 1 | Victim held a valid line |
| vic_dirty | output | 1 | Victim must be written back |
| vic_tag | output | 23 | Tag of the victim line |
| fill_en | input | 1 | Fill write strobe |
| fill_bank | input | 4 | Bank of the fill word |
| fill_way | input | 5 | Way of the fill word |
| fill_word | input | 3 | Word index within the line |
| fill_wdata | input | 32 | Fill data |
| fill_rdata | output | 32 | Previous content of the filled word |
| inst_en | input | 1 | Install tag strobe |
| inst_line | input | 27 | Line address to install (tag and bank) |
| inst_way | input | 5 | Way receiving the new tag |

## Verification
Two pairs of functions can act in the same cycle. The main case is a lookup together with a tag install: the bench installs a line while issuing a load to that same line, expects a miss, and then expects a hit on the following load. The second case is a flush together with a store hit. The store must still be reported as a hit, but its dirty mark must be lost: the next lookup misses, and the reported victim is invalid and clean. A behavioural model predicts every output in every cycle from the state it held before the edge, so the ordering of these same-cycle effects is judged directly.

// File: rtl/ccam_pkg.sv
package ccam_pkg;
  // Default organisation shared by the cache and its bench
  localparam int CCAM_ADDR_W     = 32;
  localparam int CCAM_DATA_W     = 32;
  localparam int CCAM_LINE_BYTES = 32;
  localparam int CCAM_BANKS      = 16;
  localparam int CCAM_WAYS       = 32;
endpackage

// File: rtl/ccam_tag_store.sv
module ccam_tag_store #(
  parameter  int BANKS  = 16,
  parameter  int WAYS   = 32,
  parameter  int TAG_W  = 23,
  localparam int BANK_W = $clog2(BANKS),
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [BANK_W-1:0] lk_bank,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic [WAYS-1:0]   hit_vec,
  output logic [WAYS-1:0]   lk_valid,
  output logic [WAYS-1:0]   lk_dirty,
  output logic [WAY_W-1:0]  lk_ptr,
  input  logic [WAY_W-1:0]  rd_way,
  output logic [TAG_W-1:0]  rd_tag,
  input  logic              dset_en,
  input  logic [WAY_W-1:0]  dset_way,
  input  logic              adv_en,
  input  logic              inst_en,
  input  logic [BANK_W-1:0] inst_bank,
  input  logic [WAY_W-1:0]  inst_way,
  input  logic [TAG_W-1:0]  inst_tag
);
  logic [TAG_W-1:0] tag_q   [BANKS][WAYS];
  logic [WAYS-1:0]  valid_q [BANKS];
  logic [WAYS-1:0]  dirty_q [BANKS];
  logic [WAY_W-1:0] ptr_q   [BANKS];

  // Parallel tag comparison across all ways of the selected bank
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_q[lk_bank][w] && (tag_q[lk_bank][w] == lk_tag);
  end

  assign lk_valid = valid_q[lk_bank];
  assign lk_dirty = dirty_q[lk_bank];
  assign lk_ptr   = ptr_q[lk_bank];
  assign rd_tag   = tag_q[lk_bank][rd_way];

  // Tag words carry no reset; validity is held separately
  always_ff @(posedge clk) begin
    if (inst_en) tag_q[inst_bank][inst_way] <= inst_tag;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int b = 0; b < BANKS; b++) begin
        valid_q[b] <= '0;
        dirty_q[b] <= '0;
        ptr_q[b]   <= '0;
      end
    end else begin
      if (dset_en) dirty_q[lk_bank][dset_way] <= 1'b1;
      if (adv_en)
        ptr_q[lk_bank] <= (lk_ptr == WAY_W'(WAYS - 1)) ? '0 : lk_ptr + 1'b1;
      if (inst_en) begin
        valid_q[inst_bank][inst_way] <= 1'b1;
        dirty_q[inst_bank][inst_way] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ccam_victim_pick.sv
module ccam_victim_pick #(
  parameter  int WAYS  = 32,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid,
  input  logic [WAY_W-1:0] ptr,
  output logic [WAY_W-1:0] way,
  output logic             all_valid
);
  always_comb begin
    all_valid = &valid;
    way       = ptr;
    // Scan downwards so the lowest empty way is the one kept
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid[i]) way = WAY_W'(i);
    end
  end
endmodule

// File: rtl/ccam_data_ram.sv
module ccam_data_ram #(
  parameter  int ROW_W  = 12,
  parameter  int DATA_W = 32,
  localparam int BYTE_W = DATA_W / 8,
  localparam int DEPTH  = 1 << ROW_W
) (
  input  logic              clk,
  input  logic              a_en,
  input  logic [BYTE_W-1:0] a_we,
  input  logic [ROW_W-1:0]  a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_en,
  input  logic [ROW_W-1:0]  b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Two ports, both read-before-write; port B always writes when enabled
  always_ff @(posedge clk) begin
    if (a_en) begin
      a_rdata <= mem[a_addr];
      for (int k = 0; k < BYTE_W; k++) begin
        if (a_we[k]) mem[a_addr][k*8 +: 8] <= a_wdata[k*8 +: 8];
      end
    end
    if (b_en) begin
      b_rdata      <= mem[b_addr];
      mem[b_addr]  <= b_wdata;
    end
  end
endmodule

// File: rtl/ccam_cache.sv
module ccam_cache
  import ccam_pkg::*;
#(
  parameter  int ADDR_W     = CCAM_ADDR_W,
  parameter  int DATA_W     = CCAM_DATA_W,
  parameter  int LINE_BYTES = CCAM_LINE_BYTES,
  parameter  int BANKS      = CCAM_BANKS,
  parameter  int WAYS       = CCAM_WAYS,
  localparam int BYTE_W     = DATA_W / 8,
  localparam int BOFF_W     = $clog2(BYTE_W),
  localparam int WSEL_W     = $clog2(LINE_BYTES / BYTE_W),
  localparam int BANK_W     = $clog2(BANKS),
  localparam int WAY_W      = $clog2(WAYS),
  localparam int WADDR_W    = ADDR_W - BOFF_W,
  localparam int LINE_W     = WADDR_W - WSEL_W,
  localparam int TAG_W      = LINE_W - BANK_W,
  localparam int ROW_W      = BANK_W + WAY_W + WSEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [BYTE_W-1:0]  cpu_be,
  input  logic [WADDR_W-1:0] cpu_waddr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic               cpu_hit,
  output logic               cpu_miss,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic [LINE_W-1:0]  miss_line,
  output logic [WAY_W-1:0]   vic_way,
  output logic               vic_valid,
  output logic               vic_dirty,
  output logic [TAG_W-1:0]   vic_tag,
  input  logic               fill_en,
  input  logic [BANK_W-1:0]  fill_bank,
  input  logic [WAY_W-1:0]   fill_way,
  input  logic [WSEL_W-1:0]  fill_word,
  input  logic [DATA_W-1:0]  fill_wdata,
  output logic [DATA_W-1:0]  fill_rdata,
  input  logic               inst_en,
  input  logic [LINE_W-1:0]  inst_line,
  input  logic [WAY_W-1:0]   inst_way
);
  // Address fields of the request
  logic [WSEL_W-1:0] req_word;
  logic [BANK_W-1:0] req_bank;
  logic [TAG_W-1:0]  req_tag;
  assign req_word = cpu_waddr[WSEL_W-1:0];
  assign req_bank = cpu_waddr[WSEL_W +: BANK_W];
  assign req_tag  = cpu_waddr[WADDR_W-1 -: TAG_W];

  logic [WAYS-1:0]  hit_vec, lk_valid, lk_dirty;
  logic [WAY_W-1:0] lk_ptr, pick_way, hit_way;
  logic [TAG_W-1:0] pick_tag;
  logic             all_valid, hit_any, look_hit, look_miss;

  assign hit_any   = |hit_vec;
  assign look_hit  = cpu_req && hit_any;
  assign look_miss = cpu_req && !hit_any;

  // One-hot match to way number; the match is unique by design
  always_comb begin
    hit_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (hit_vec[i]) hit_way = hit_way | WAY_W'(i);
    end
  end

  ccam_tag_store #(.BANKS(BANKS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .lk_bank   (req_bank),
    .lk_tag    (req_tag),
    .hit_vec   (hit_vec),
    .lk_valid  (lk_valid),
    .lk_dirty  (lk_dirty),
    .lk_ptr    (lk_ptr),
    .rd_way    (pick_way),
    .rd_tag    (pick_tag),
    .dset_en   (look_hit && cpu_we),
    .dset_way  (hit_way),
    .adv_en    (look_miss && all_valid),
    .inst_en   (inst_en),
    .inst_bank (inst_line[BANK_W-1:0]),
    .inst_way  (inst_way),
    .inst_tag  (inst_line[LINE_W-1:BANK_W])
  );

  ccam_victim_pick #(.WAYS(WAYS)) u_pick (
    .valid     (lk_valid),
    .ptr       (lk_ptr),
    .way       (pick_way),
    .all_valid (all_valid)
  );

  // Only the matching row is enabled on the processor port
  ccam_data_ram #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .a_en    (look_hit),
    .a_we    (cpu_we ? cpu_be : '0),
    .a_addr  ({req_bank, hit_way, req_word}),
    .a_wdata (cpu_wdata),
    .a_rdata (cpu_rdata),
    .b_en    (fill_en),
    .b_addr  ({fill_bank, fill_way, fill_word}),
    .b_wdata (fill_wdata),
    .b_rdata (fill_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_hit  <= 1'b0;
      cpu_miss <= 1'b0;
    end else begin
      cpu_hit  <= look_hit;
      cpu_miss <= look_miss;
    end
  end

  always_ff @(posedge clk) begin
    if (look_miss) begin
      miss_line <= cpu_waddr[WADDR_W-1:WSEL_W];
      vic_way   <= pick_way;
      vic_valid <= lk_valid[pick_way];
      vic_dirty <= lk_dirty[pick_way];
      vic_tag   <= pick_tag;
    end
  end
endmodule

// File: rtl/ccam_cache_chk.sv
module ccam_cache_chk #(
  parameter int WAYS = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            flush,
  input logic            cpu_req,
  input logic            cpu_hit,
  input logic            cpu_miss,
  input logic [WAYS-1:0] hit_vec
);
  logic flush_d;
  always_ff @(posedge clk) flush_d <= rst ? 1'b0 : flush;

  // R2: the associative search never finds two ways
  a_r2_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R2: every request is answered in the next cycle
  a_r2_answer_next: assert property (@(posedge clk) disable iff (rst)
    cpu_req |=> (cpu_hit || cpu_miss));

  // R4: hit and miss exclude each other
  a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(cpu_hit && cpu_miss));

  // R4: no answer without a request
  a_r4_quiet: assert property (@(posedge clk) disable iff (rst)
    !cpu_req |=> !(cpu_hit || cpu_miss));

  // R10: right after a flush nothing can hit
  a_r10_flush_empty: assert property (@(posedge clk) disable iff (rst)
    (flush_d && cpu_req) |=> cpu_miss);
endmodule

bind ccam_cache ccam_cache_chk #(.WAYS(WAYS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .flush    (flush),
  .cpu_req  (cpu_req),
  .cpu_hit  (cpu_hit),
  .cpu_miss (cpu_miss),
  .hit_vec  (hit_vec)
);

// File: tb/sim_ccam_cache.sv
`timescale 1ns/1ps
module sim_ccam_cache;
  localparam int NB = 16, NW = 32, WPL = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1, flush = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [3:0]  cpu_be = '0;
  logic [29:0] cpu_waddr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_hit, cpu_miss;
  logic [31:0] cpu_rdata;
  logic [26:0] miss_line;
  logic [4:0]  vic_way;
  logic        vic_valid, vic_dirty;
  logic [22:0] vic_tag;
  logic        fill_en = 1'b0;
  logic [3:0]  fill_bank = '0;
  logic [4:0]  fill_way = '0;
  logic [2:0]  fill_word = '0;
  logic [31:0] fill_wdata = '0;
  logic [31:0] fill_rdata;
  logic        inst_en = 1'b0;
  logic [26:0] inst_line = '0;
  logic [4:0]  inst_way = '0;

  ccam_cache u0 (
    .clk(clk), .rst(rst), .flush(flush),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_be(cpu_be),
    .cpu_waddr(cpu_waddr), .cpu_wdata(cpu_wdata),
    .cpu_hit(cpu_hit), .cpu_miss(cpu_miss), .cpu_rdata(cpu_rdata),
    .miss_line(miss_line), .vic_way(vic_way), .vic_valid(vic_valid),
    .vic_dirty(vic_dirty), .vic_tag(vic_tag),
    .fill_en(fill_en), .fill_bank(fill_bank), .fill_way(fill_way),
    .fill_word(fill_word), .fill_wdata(fill_wdata), .fill_rdata(fill_rdata),
    .inst_en(inst_en), .inst_line(inst_line), .inst_way(inst_way)
  );

  int    vectors = 0, errors = 0;
  string req_tag = "R10";
  bit    done = 0;

  // Behavioural reference state
  bit          mv [NB][NW];
  bit          md [NB][NW];
  logic [22:0] mt [NB][NW];
  int          mrr [NB];
  logic [31:0] mmem [int];

  bit          e_hit, e_miss, c_rd, c_vic, c_frd, e_vv, e_vd;
  logic [31:0] e_rd, e_frd;
  logic [26:0] e_line;
  int          e_way;
  logic [22:0] e_vtag;

  function automatic logic [31:0] mk(int tag, int bank, int word);
    return (32'(tag) << 9) | (32'(bank) << 5) | (32'(word) << 2);
  endfunction

  function automatic int row(int b, int w, int k);
    return (b * NW + w) * WPL + k;
  endfunction

  task automatic wipe();
    for (int b = 0; b < NB; b++) begin
      mrr[b] = 0;
      for (int w = 0; w < NW; w++) begin mv[b][w] = 0; md[b][w] = 0; end
    end
  endtask

  task automatic model_step();
    int b, hw, vi, r, ib;
    logic [31:0] v;
    c_rd = 0; c_vic = 0; c_frd = 0; e_hit = 0; e_miss = 0;
    if (rst) begin wipe(); return; end
    b  = int'(cpu_waddr[6:3]);
    hw = -1;
    if (cpu_req) begin
      for (int w = 0; w < NW; w++)
        if (mv[b][w] && mt[b][w] == cpu_waddr[29:7]) hw = w;
      if (hw >= 0) begin
        e_hit = 1;
        r = row(b, hw, int'(cpu_waddr[2:0]));
        if (!cpu_we && mmem.exists(r)) begin c_rd = 1; e_rd = mmem[r]; end
        if (cpu_we) begin
          v = mmem.exists(r) ? mmem[r] : 32'h0;
          for (int k = 0; k < 4; k++)
            if (cpu_be[k]) v[k*8 +: 8] = cpu_wdata[k*8 +: 8];
          mmem[r] = v;
          md[b][hw] = 1;
        end
      end else begin
        e_miss = 1; c_vic = 1;
        e_line = cpu_waddr[29:3];
        vi = -1;
        for (int w = 0; w < NW; w++) if (!mv[b][w] && vi < 0) vi = w;
        if (vi < 0) begin vi = mrr[b]; mrr[b] = (mrr[b] + 1) % NW; end
        e_way = vi; e_vv = mv[b][vi]; e_vd = md[b][vi]; e_vtag = mt[b][vi];
      end
    end
    if (fill_en) begin
      r = row(int'(fill_bank), int'(fill_way), int'(fill_word));
      if (mmem.exists(r)) begin c_frd = 1; e_frd = mmem[r]; end
      mmem[r] = fill_wdata;
    end
    if (inst_en) begin
      ib = int'(inst_line[3:0]);
      mv[ib][inst_way] = 1; md[ib][inst_way] = 0; mt[ib][inst_way] = inst_line[26:4];
    end
    if (flush) wipe();
  endtask

  task automatic chk(string what, logic [63:0] got, logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req_tag, what, got, exp);
    end
  endtask

  task automatic compare();
    chk("hit", 64'(cpu_hit), 64'(e_hit));
    chk("miss", 64'(cpu_miss), 64'(e_miss));
    if (c_rd) chk("rdata", 64'(cpu_rdata), 64'(e_rd));
    if (c_vic) begin
      chk("miss_line", 64'(miss_line), 64'(e_line));
      chk("vic_way", 64'(vic_way), 64'(e_way));
      chk("vic_valid", 64'(vic_valid), 64'(e_vv));
      chk("vic_dirty", 64'(vic_dirty), 64'(e_vd));
      if (e_vv) chk("vic_tag", 64'(vic_tag), 64'(e_vtag));
    end
    if (c_frd) chk("fill_rdata", 64'(fill_rdata), 64'(e_frd));
  endtask

  task automatic idle();
    cpu_req = 0; cpu_we = 0; cpu_be = '0; fill_en = 0; inst_en = 0; flush = 0;
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    idle();
  endtask

  task automatic set_load(logic [31:0] a);
    cpu_req = 1; cpu_we = 0; cpu_waddr = a[31:2];
  endtask

  task automatic set_store(logic [31:0] a, logic [3:0] be, logic [31:0] d);
    cpu_req = 1; cpu_we = 1; cpu_waddr = a[31:2]; cpu_be = be; cpu_wdata = d;
  endtask

  task automatic set_inst(logic [31:0] a, int way);
    inst_en = 1; inst_line = a[31:5]; inst_way = 5'(way);
  endtask

  task automatic fill_line(int bank, int way, logic [31:0] base);
    for (int k = 0; k < WPL; k++) begin
      fill_en = 1; fill_bank = 4'(bank); fill_way = 5'(way);
      fill_word = 3'(k); fill_wdata = base + 32'(k);
      tick();
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      vectors++; errors++;
      $display("FAIL watchdog: got hung run expected completion");
      report();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R10: reset state
    req_tag = "R10";
    rst = 1; tick(); rst = 1; tick(); rst = 0;

    // R4 and R5: load miss in an empty bank, then a store miss
    req_tag = "R4";
    set_load(mk(5, 3, 1)); tick();
    set_store(mk(5, 3, 2), 4'hF, 32'hDEAD_BEEF); tick();
    set_load(mk(5, 3, 2)); tick();

    // R8 fill, then R9 install while the same line is looked up
    req_tag = "R8";
    fill_line(3, 0, 32'hA000_0000);
    req_tag = "R9";
    set_inst(mk(5, 3, 0), 0); set_load(mk(5, 3, 4)); tick();
    req_tag = "R2";
    for (int k = 0; k < WPL; k++) begin set_load(mk(5, 3, k)); tick(); end

    // R1: same tag in a neighbouring bank is a separate line
    req_tag = "R1";
    fill_line(4, 0, 32'hB000_0000);
    set_inst(mk(5, 4, 0), 0); tick();
    set_load(mk(5, 4, 1)); tick();
    set_load(mk(5, 3, 1)); tick();

    // R3: byte-enabled store hits
    req_tag = "R3";
    set_store(mk(5, 3, 2), 4'b0101, 32'h1122_3344); tick();
    set_load(mk(5, 3, 2)); tick();
    set_store(mk(5, 3, 3), 4'b1000, 32'h9900_0000); tick();
    set_load(mk(5, 3, 3)); tick();

    // R5: lowest empty way preferred
    req_tag = "R5";
    set_inst(mk(7, 3, 0), 2); tick();
    set_load(mk(9, 3, 0)); tick();

    // R6 and R7: full bank, pointer walk, dirty victim report
    req_tag = "R6";
    for (int w = 1; w < NW; w++) if (w != 2) begin set_inst(mk(40 + w, 3, 0), w); tick(); end
    req_tag = "R7";
    set_load(mk(99, 3, 0)); tick();
    req_tag = "R6";
    set_load(mk(98, 3, 0)); tick();
    set_load(mk(97, 3, 5)); tick();
    for (int w = 0; w < NW; w++) begin set_inst(mk(60 + w, 6, 0), w); tick(); end
    set_load(mk(96, 6, 0)); tick();
    req_tag = "R5";
    set_load(mk(95, 4, 0)); tick();

    // R8: refill returns old words, including the modified ones
    req_tag = "R8";
    fill_line(3, 0, 32'hC000_0000);
    req_tag = "R9";
    set_inst(mk(20, 3, 0), 0); tick();
    set_load(mk(20, 3, 2)); tick();
    req_tag = "R7";
    set_store(mk(20, 3, 6), 4'hF, 32'h0BAD_F00D); tick();

    // R10: flush together with a store hit
    req_tag = "R10";
    flush = 1; set_store(mk(20, 3, 1), 4'hF, 32'h5555_AAAA); tick();
    set_load(mk(20, 3, 1)); tick();
    set_load(mk(96, 6, 0)); tick();
    req_tag = "R4";
    tick();

    done = 1;
    report();
    $finish;
  end
endmodule